// File: doc/BRIEF.md
# Strap-Configured Clock Gating Controller

This block is the digital control section of a multi-output clock generator. Right after power-on, a set of dual-purpose pads acts as inputs. The block captures their levels as configuration straps for the host frequency code, the PCI clock source, the fixed-clock pair and the PCI clock-off behaviour. After a power-up window measured in reference ticks, it raises a pad output enable so that the same pads carry clocks from then on.

Once running, two active-low power-management inputs select one of four power modes:

- **Run**: every clock runs.
- **Slow**: the host clock is retargeted to its slow rate.
- **Clock-off**: the tail host outputs are stopped, and the gated PCI outputs follow a strap.
- **All-off**: every output stops, and the PLL and oscillator enables drop.

The power-management inputs pass through synchronizers before they reach the registered gating. Three clamp outputs act asynchronously, straight from the raw pins. An enable changes only while its clock is low, and leaving all-off waits for a stabilization count before any output is enabled again.

The synthesizer itself is not part of this block. It reports the current level of each source clock through the level inputs and consumes the enables, clamps and select signals.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `rst_n` is low and until `pad_oe` rises, `pad_oe` is 0 and the pads are sampled every tick. A pad that nothing drives reads as 1 through its pull-up and is captured as 1.
- R2: `pad_oe` rises exactly POR_TICKS rising edges after `rst_n` is released and then stays 1. The configuration holds the last value sampled before that edge, and later pad changes leave it unchanged.
- R3: The straps decode by pad bit as follows:
  - `cfg_host_sel` = pad[1:0], with 00=66.66, 01=60, 10=75 and 11=50 MHz.
  - `cfg_pci_sync` = pad[2], with 0=asynchronous 33.33 MHz and 1=host/2.
  - `cfg_fix_sel` = pad[4:3], with the pairs 00=14.318/14.318, 01=14.318/48, 10=24/14.318 and 11=16.934/24.576.
  - `cfg_ps` = pad[5].
- R4: While `pad_oe` is 0, all five clock enables are 0.
- R5: With stop_n=1 and slow_n=1, the outputs are as follows, NSYNC+1 edges after the inputs settle:
  - all five enables are 1;
  - `host_slow_sel` is 0;
  - `pll_en` and `osc_en` are 1.
- R6: With stop_n=1 and slow_n=0, `host_slow_sel` is 1 (host at 33.33 MHz) and all five enables stay 1, NSYNC+1 edges after the change.
- R7: With stop_n=0 and slow_n=0 (clock-off), the following hold NSYNC+1 edges after the change:
  - `en_host_b` is 0;
  - `en_host_a`, `en_pcif` and `en_fix` are 1;
  - `en_pci` equals `cfg_ps`.
- R8: With stop_n=0 and slow_n=1 (all-off), all enables, `pll_en` and `osc_en` are 0 NSYNC+1 edges after the change.
- R9: The clamps follow the raw pins with no clock edge:
  - `clamp_host_b` = !stop_n;
  - `clamp_all` = !stop_n & slow_n;
  - `clamp_pci` = !stop_n & (slow_n | !cfg_ps).
- R10: When leaving all-off, `pll_en` returns after NSYNC+1 edges. The clock enables return only NSYNC+1+STAB_TICKS edges after the input change, and are still 0 one edge before that.
- R11: Each clock enable and `host_slow_sel` changes only at a rising edge where the level of its source clock (host, PCI or fixed) was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pad_in | input | 6 | Levels read back from the dual-purpose pads |
| stop_n | input | 1 | Power-management stop request, active low |
| slow_n | input | 1 | Power-management slow request, active low |
| host_lvl | input | 1 | Current level of the host source clock |
| pci_lvl | input | 1 | Current level of the PCI source clock |
| fix_lvl | input | 1 | Current level of the fixed source clock |
| pad_oe | output | 1 | Turns the dual-purpose pads into outputs |
| cfg_host_sel | output | 2 | Latched host frequency code |
| cfg_pci_sync | output | 1 | Latched PCI source select |
| cfg_fix_sel | output | 2 | Latched fixed-pair select |
| cfg_ps | output | 1 | Latched PCI clock-off behaviour |
| en_host_a | output | 1 | Enable for host 1-4 and the early host output |
| en_host_b | output | 1 | Enable for host outputs 5 and 7 |
| en_pci | output | 1 | Enable for the gated PCI outputs |
| en_pcif | output | 1 | Enable for the free-running PCI output |
| en_fix | output | 1 | Enable for F1, F2 and the reference output |
| host_slow_sel | output | 1 | Host frequency select: 1 picks 33.33 MHz |
| clamp_host_b | output | 1 | Asynchronous low clamp for host 5 and 7 |
| clamp_pci | output | 1 | Asynchronous low clamp for the gated PCI outputs |
| clamp_all | output | 1 | Asynchronous low clamp for every output |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The registered results are due at fixed distances from the stimulus:

- A change on stop_n or slow_n shows on the enables, the host select and the PLL/oscillator enables after exactly NSYNC+1 rising edges.
- The exit from all-off holds the clock enables for a further STAB_TICKS edges.
- `pad_oe` rises POR_TICKS edges after reset release.
- The clamps follow the pins within the same time step.

For every stimulus, the driver queues each expected value with the edge count at which it is due. It also queues the old value one edge earlier, so both early and late changes are caught. The monitor samples at the falling edge of the cycle in which each item is due. A separate check, with the source levels toggling, confirms that each enable change follows an edge at which its clock was low.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

   localparam int STRAP_W = 6;

   // Encoding is {stop_n, slow_n}
   typedef enum logic [1:0] {
      PM_CLKOFF = 2'b00,
      PM_ALLOFF = 2'b01,
      PM_SLOW   = 2'b10,
      PM_RUN    = 2'b11
   } pmode_e;

   // Packed so that bit positions match the pad numbering
   typedef struct packed {
      logic       ps;
      logic [1:0] fix_sel;
      logic       pci_sync;
      logic [1:0] host_sel;
   } strap_cfg_t;

   // Gated output groups
   localparam int G_HOSTA = 0;
   localparam int G_HOSTB = 1;
   localparam int G_PCI   = 2;
   localparam int G_PCIF  = 3;
   localparam int G_FIX   = 4;
   localparam int G_SLOW  = 5;
   localparam int NGRP    = 6;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
   parameter int W = 2,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cg_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= RST_VAL;
         end else begin
            if (s == 0) chain[s] <= d;
            else        chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_strap.sv
module cg_strap
   import clkgate_pkg::*;
#(
   parameter int POR_TICKS = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] pad_in,
   output strap_cfg_t         cfg,
   output logic               pad_oe
);
   if (POR_TICKS < 1) begin : g_bad_por
      $error("POR_TICKS must be at least 1");
   end

   localparam int PW = $clog2(POR_TICKS + 1);

   logic [PW-1:0] por_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_cnt <= '0;
         pad_oe  <= 1'b0;
      end else if (!pad_oe) begin
         if (por_cnt == PW'(POR_TICKS - 1)) pad_oe  <= 1'b1;
         else                               por_cnt <= por_cnt + 1'b1;
      end
   end

   // Sampling runs during reset as well; the pad model supplies pull-ups
   always_ff @(posedge clk) begin
      if (!pad_oe) cfg <= strap_cfg_t'(pad_in);
   end

   assert_oe_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pad_oe) |-> pad_oe);

   assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe && $past(pad_oe)) |-> $stable(cfg));
endmodule

// File: rtl/cg_mode_fsm.sv
module cg_mode_fsm
   import clkgate_pkg::*;
#(
   parameter int NSYNC = 2,
   parameter int STAB_TICKS = 16
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   stop_n,
   input  logic   slow_n,
   output pmode_e mode,
   output logic   settled,
   output logic   pll_en,
   output logic   osc_en
);
   if (STAB_TICKS < 1) begin : g_bad_stab
      $error("STAB_TICKS must be at least 1");
   end

   localparam int CW = $clog2(STAB_TICKS + 1);

   logic [1:0]    pm_sync;
   logic [CW-1:0] stab_cnt;

   cg_sync #(.W(2), .STAGES(NSYNC), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({stop_n, slow_n}),
      .q     (pm_sync)
   );

   assign mode = pmode_e'(pm_sync);

   // Reloaded throughout all-off; counts down once all-off is left
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stab_cnt <= '0;
      end else if (mode == PM_ALLOFF) begin
         stab_cnt <= CW'(STAB_TICKS);
      end else if (stab_cnt != '0) begin
         stab_cnt <= stab_cnt - 1'b1;
      end
   end

   assign settled = (stab_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_en <= 1'b0;
         osc_en <= 1'b0;
      end else begin
         pll_en <= (mode != PM_ALLOFF);
         osc_en <= (mode != PM_ALLOFF);
      end
   end

   assert_settle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_ALLOFF) |=> !settled);
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic d,
   output logic q
);
   // Loads only while the gated clock is low, so it never cuts a high phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (!lvl) q <= d;
   end

   assert_no_runt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> !$past(lvl));
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
   import clkgate_pkg::*;
#(
   parameter int NSYNC = 2,
   parameter int POR_TICKS = 20,
   parameter int STAB_TICKS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] pad_in,
   input  logic               stop_n,
   input  logic               slow_n,
   input  logic               host_lvl,
   input  logic               pci_lvl,
   input  logic               fix_lvl,
   output logic               pad_oe,
   output logic [1:0]         cfg_host_sel,
   output logic               cfg_pci_sync,
   output logic [1:0]         cfg_fix_sel,
   output logic               cfg_ps,
   output logic               en_host_a,
   output logic               en_host_b,
   output logic               en_pci,
   output logic               en_pcif,
   output logic               en_fix,
   output logic               host_slow_sel,
   output logic               clamp_host_b,
   output logic               clamp_pci,
   output logic               clamp_all,
   output logic               pll_en,
   output logic               osc_en
);
   strap_cfg_t      cfg;
   pmode_e          mode;
   logic            settled;
   logic            ready;
   logic [NGRP-1:0] want;
   logic [NGRP-1:0] lvl_of;
   logic [NGRP-1:0] en_q;

   cg_strap #(.POR_TICKS(POR_TICKS)) u_strap (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_in (pad_in),
      .cfg    (cfg),
      .pad_oe (pad_oe)
   );

   cg_mode_fsm #(.NSYNC(NSYNC), .STAB_TICKS(STAB_TICKS)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop_n  (stop_n),
      .slow_n  (slow_n),
      .mode    (mode),
      .settled (settled),
      .pll_en  (pll_en),
      .osc_en  (osc_en)
   );

   assign ready = pad_oe && settled;

   always_comb begin
      want          = '0;
      want[G_HOSTA] = ready && (mode != PM_ALLOFF);
      want[G_HOSTB] = ready && (mode == PM_RUN || mode == PM_SLOW);
      want[G_PCI]   = ready && (mode == PM_RUN || mode == PM_SLOW ||
                                (mode == PM_CLKOFF && cfg.ps));
      want[G_PCIF]  = ready && (mode != PM_ALLOFF);
      want[G_FIX]   = ready && (mode != PM_ALLOFF);
      want[G_SLOW]  = (mode == PM_SLOW);
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_gate
      if (g == G_PCI || g == G_PCIF) begin : g_src_pci
         assign lvl_of[g] = pci_lvl;
      end else if (g == G_FIX) begin : g_src_fix
         assign lvl_of[g] = fix_lvl;
      end else begin : g_src_host
         assign lvl_of[g] = host_lvl;
      end

      cg_gate_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (lvl_of[g]),
         .d     (want[g]),
         .q     (en_q[g])
      );
   end

   assign en_host_a     = en_q[G_HOSTA];
   assign en_host_b     = en_q[G_HOSTB];
   assign en_pci        = en_q[G_PCI];
   assign en_pcif       = en_q[G_PCIF];
   assign en_fix        = en_q[G_FIX];
   assign host_slow_sel = en_q[G_SLOW];

   // Asynchronous clamps taken straight from the raw pins
   assign clamp_host_b = !stop_n;
   assign clamp_all    = !stop_n && slow_n;
   assign clamp_pci    = !stop_n && (slow_n || !cfg.ps);

   assign cfg_host_sel = cfg.host_sel;
   assign cfg_pci_sync = cfg.pci_sync;
   assign cfg_fix_sel  = cfg.fix_sel;
   assign cfg_ps       = cfg.ps;

   assert_prewin_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe |-> !(en_host_a || en_host_b || en_pci || en_pcif || en_fix));

   assert_alloff_pll_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_ALLOFF) |=> (!pll_en && !osc_en));

   assert_clkoff_hostb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_CLKOFF && !host_lvl) |=> !en_host_b);
endmodule

// File: tb/tb_clkgate_ctrl.sv
module tb_clkgate_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NSYNC = 2;
   localparam int POR = 20;
   localparam int STAB = 16;
   localparam int LAT = NSYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] drv_en = '1;
   logic [5:0] drv_val = '0;
   logic [5:0] pad_in;
   logic stop_n = 1'b1, slow_n = 1'b1;
   logic host_lvl = 1'b0, pci_lvl = 1'b0, fix_lvl = 1'b0;
   bit   lvl_run = 1'b0;

   logic pad_oe, cfg_pci_sync, cfg_ps;
   logic [1:0] cfg_host_sel, cfg_fix_sel;
   logic en_host_a, en_host_b, en_pci, en_pcif, en_fix, host_slow_sel;
   logic clamp_host_b, clamp_pci, clamp_all, pll_en, osc_en;

   // Pad model: an undriven pad is pulled up to 1
   assign pad_in = (drv_en & drv_val) | ~drv_en;

   clkgate_ctrl #(.NSYNC(NSYNC), .POR_TICKS(POR), .STAB_TICKS(STAB)) dut (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .stop_n(stop_n), .slow_n(slow_n),
      .host_lvl(host_lvl), .pci_lvl(pci_lvl), .fix_lvl(fix_lvl),
      .pad_oe(pad_oe), .cfg_host_sel(cfg_host_sel), .cfg_pci_sync(cfg_pci_sync),
      .cfg_fix_sel(cfg_fix_sel), .cfg_ps(cfg_ps),
      .en_host_a(en_host_a), .en_host_b(en_host_b), .en_pci(en_pci),
      .en_pcif(en_pcif), .en_fix(en_fix), .host_slow_sel(host_slow_sel),
      .clamp_host_b(clamp_host_b), .clamp_pci(clamp_pci), .clamp_all(clamp_all),
      .pll_en(pll_en), .osc_en(osc_en)
   );

   int  cyc = 0;
   int  checks = 0;
   int  fails = 0;
   bit  done = 0;
   int  runt_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // Scoreboard
   typedef struct {
      int    due;
      int    sig;
      logic  exp;
      string req;
   } item_t;
   item_t sb[$];

   function automatic logic obs(int s);
      case (s)
         0: return en_host_a;
         1: return en_host_b;
         2: return en_pci;
         3: return en_pcif;
         4: return en_fix;
         5: return host_slow_sel;
         6: return pll_en;
         default: return osc_en;
      endcase
   endfunction

   function automatic string sname(int s);
      case (s)
         0: return "en_host_a";
         1: return "en_host_b";
         2: return "en_pci";
         3: return "en_pcif";
         4: return "en_fix";
         5: return "host_slow_sel";
         6: return "pll_en";
         default: return "osc_en";
      endcase
   endfunction

   // Expected outputs from the requirements; bit order as in obs()
   function automatic logic [7:0] exp_vec(logic st, logic sl, logic ps, logic rdy);
      logic alloff;
      logic [7:0] v;
      alloff = !st && sl;
      v[0] = rdy && !alloff;
      v[1] = rdy && st;
      v[2] = rdy && (st || (!sl && ps));
      v[3] = rdy && !alloff;
      v[4] = rdy && !alloff;
      v[5] = st && !sl;
      v[6] = !alloff;
      v[7] = !alloff;
      return v;
   endfunction

   task automatic push_vec(int due, logic [7:0] v, string req);
      for (int s = 0; s < 8; s++) begin
         item_t it;
         it.due = due; it.sig = s; it.exp = v[s]; it.req = req;
         sb.push_back(it);
      end
   endtask

   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         if (it.due < cyc) begin
            checks++; fails++;
            $display("FAIL %s %s missed actual=%0d expected=%0d", it.req, sname(it.sig), cyc, it.due);
         end else begin
            chk(it.req, sname(it.sig), obs(it.sig), it.exp);
         end
      end
   end

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
   endtask

   // Abstract divided clocks
   int ldiv = 0;
   always @(negedge clk) begin
      if (lvl_run) begin
         ldiv++;
         host_lvl = ~host_lvl;
         if (ldiv % 2 == 0) pci_lvl = ~pci_lvl;
         if (ldiv % 3 == 0) fix_lvl = ~fix_lvl;
      end else begin
         host_lvl = 1'b0; pci_lvl = 1'b0; fix_lvl = 1'b0;
      end
   end

   // R11 monitor: an enable may change only after an edge with its clock low
   logic hl_q = 0, pl_q = 0, fl_q = 0;
   logic eb_p = 0, ep_p = 0, ef_p = 0;
   always @(posedge clk) begin
      hl_q <= host_lvl; pl_q <= pci_lvl; fl_q <= fix_lvl;
   end
   always @(negedge clk) begin
      if (rst_n && lvl_run) begin
         if (en_host_b !== eb_p) begin runt_seen++; chk("R11", "host level at en_host_b change", hl_q, 0); end
         if (en_pci !== ep_p)    begin runt_seen++; chk("R11", "pci level at en_pci change", pl_q, 0); end
         if (en_fix !== ef_p)    begin runt_seen++; chk("R11", "fix level at en_fix change", fl_q, 0); end
      end
      eb_p = en_host_b; ep_p = en_pci; ef_p = en_fix;
   end

   task automatic set_mode(logic st, logic sl, logic ps, logic rdy_after, string req);
      int n;
      logic [7:0] old_v;
      @(negedge clk);
      old_v = exp_vec(stop_n, slow_n, ps, 1'b1);
      n = cyc;
      stop_n = st; slow_n = sl;
      push_vec(n + LAT - 1, old_v, req);
      push_vec(n + LAT, exp_vec(st, sl, ps, rdy_after), req);
   endtask

   task automatic power_up(logic [5:0] en_a, logic [5:0] val_a,
                           logic [5:0] en_b, logic [5:0] val_b, logic ps);
      int r;
      @(negedge clk);
      rst_n = 1'b0; stop_n = 1'b1; slow_n = 1'b1;
      drv_en = en_a; drv_val = val_a;
      repeat (4) @(negedge clk);
      chk("R1", "pad_oe in reset", pad_oe, 0);
      chk("R4", "en_host_a in reset", en_host_a, 0);
      chk("R4", "en_pcif in reset", en_pcif, 0);
      chk("R8", "pll_en in reset", pll_en, 0);
      rst_n = 1'b1;
      r = cyc;
      push_vec(r + POR, exp_vec(1'b1, 1'b1, ps, 1'b0), "R4");
      push_vec(r + POR + 1, exp_vec(1'b1, 1'b1, ps, 1'b1), "R5");
      while (cyc < r + POR - 1) @(negedge clk);
      chk("R2", "pad_oe one edge before window end", pad_oe, 0);
      drv_en = en_b; drv_val = val_b;
      @(negedge clk);
      chk("R2", "pad_oe at window end", pad_oe, 1);
      drain();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // First power-up: late pattern leaves bits 5, 3 and 0 undriven
      // pad = 6'b101001: ps=1, fix=01, pci_sync=0, host=01
      power_up(6'b111111, 6'b010110, 6'b010110, 6'b000000, 1'b1);
      chk("R1", "cfg_ps from undriven pad", cfg_ps, 1);
      chk("R3", "cfg_host_sel", cfg_host_sel, 2'b01);
      chk("R3", "cfg_pci_sync", cfg_pci_sync, 0);
      chk("R3", "cfg_fix_sel", cfg_fix_sel, 2'b01);

      // Pads change after the window: configuration unchanged
      drv_en = '1; drv_val = 6'b010110;
      repeat (3) @(negedge clk);
      chk("R2", "cfg_host_sel frozen", cfg_host_sel, 2'b01);
      chk("R2", "cfg_fix_sel frozen", cfg_fix_sel, 2'b01);
      chk("R2", "cfg_ps frozen", cfg_ps, 1);
      chk("R2", "pad_oe stays", pad_oe, 1);

      set_mode(1'b1, 1'b0, 1'b1, 1'b1, "R6");
      #1;
      chk("R9", "clamp_host_b in slow", clamp_host_b, 0);
      drain();
      set_mode(1'b1, 1'b1, 1'b1, 1'b1, "R5");
      drain();

      set_mode(1'b0, 1'b0, 1'b1, 1'b1, "R7");
      #1;
      chk("R9", "clamp_host_b in clock-off", clamp_host_b, 1);
      chk("R9", "clamp_pci in clock-off with ps=1", clamp_pci, 0);
      chk("R9", "clamp_all in clock-off", clamp_all, 0);
      drain();

      set_mode(1'b0, 1'b1, 1'b1, 1'b0, "R8");
      #1;
      chk("R9", "clamp_all in all-off", clamp_all, 1);
      chk("R9", "clamp_pci in all-off", clamp_pci, 1);
      chk("R9", "clamp_host_b in all-off", clamp_host_b, 1);
      drain();
      repeat (4) @(negedge clk);

      // Leave all-off: PLL back after LAT, enables after LAT+STAB
      begin
         int n;
         @(negedge clk);
         n = cyc;
         stop_n = 1'b1;
         #1;
         chk("R9", "clamp_all released", clamp_all, 0);
         chk("R9", "clamp_host_b released", clamp_host_b, 0);
         push_vec(n + LAT - 1, exp_vec(1'b0, 1'b1, 1'b1, 1'b0), "R10");
         push_vec(n + LAT, exp_vec(1'b1, 1'b1, 1'b1, 1'b0), "R10");
         push_vec(n + LAT + STAB - 1, exp_vec(1'b1, 1'b1, 1'b1, 1'b0), "R10");
         push_vec(n + LAT + STAB, exp_vec(1'b1, 1'b1, 1'b1, 1'b1), "R10");
         drain();
      end

      // Second power-up: all pads driven, 6'b011110 gives ps=0, fix=11, pci_sync=1, host=10
      power_up(6'b111111, 6'b000000, 6'b111111, 6'b011110, 1'b0);
      chk("R3", "cfg_host_sel second strap", cfg_host_sel, 2'b10);
      chk("R3", "cfg_pci_sync second strap", cfg_pci_sync, 1);
      chk("R3", "cfg_fix_sel second strap", cfg_fix_sel, 2'b11);
      chk("R3", "cfg_ps second strap", cfg_ps, 0);

      set_mode(1'b0, 1'b0, 1'b0, 1'b1, "R7");
      #1;
      chk("R9", "clamp_pci in clock-off with ps=0", clamp_pci, 1);
      drain();
      set_mode(1'b1, 1'b1, 1'b0, 1'b1, "R5");
      drain();

      // Toggling source clocks: enables must change only on low phases
      lvl_run = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); stop_n = 1'b0; slow_n = 1'b0;
         repeat (12) @(negedge clk);
         stop_n = 1'b1; slow_n = 1'b1;
         repeat (12) @(negedge clk);
         stop_n = 1'b0; slow_n = 1'b1;
         repeat (12) @(negedge clk);
         stop_n = 1'b1;
         repeat (STAB + 12) @(negedge clk);
      end
      lvl_run = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11", "enable changes observed", (runt_seen > 0) ? 1 : 0, 1);
      chk("R5", "en_host_b after toggling run", en_host_b, 1);
      chk("R5", "en_fix after toggling run", en_fix, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule